// File: doc/BRIEF.md
# Outstanding memory request tracker

The tracker sits between a processor's load/store path and a cache controller and records every memory request that is still in flight. Requests fall into two classes. Read-class requests are kept in a read table and write-class requests in a write table. Both tables are fully associative and are keyed by cache-line address, which is the request address with the line-offset bits cleared.

Each new request is first checked against a global limit on outstanding entries. It is then checked for aliasing against both tables. The result is one of three outcomes: it is issued and inserted, it is refused as aliased, or it is refused because the tracker is full.

Two completion ports, one for reads and one for writes, retire entries by line address. A completion that hits reports the request's latency. A completion that matches no entry sets a sticky protocol-error flag. Every entry is stamped with the cycle in which it was issued, and a deadlock alarm is raised while any pending entry has reached a configurable age.

Top module: `mem_req_tracker`

## Requirements
- R1: While the outstanding count equals MAX_OUT, every request gets status 2'b11 (full) and is not inserted, even if it would also alias.
- R2: Type codes 2 (store), 3 (rmw read), 4 (rmw write), 5 (load-linked), 6 (store-conditional), 7 (locked rmw read), 8 (locked rmw write) and 9 (flush) are write-class and go to the write table. Every other code is read-class and goes to the read table; this includes 0 (load) and 1 (instruction fetch).
- R3: A write-class request whose line matches a pending read entry gets status 2'b10 (aliased) and is not inserted.
- R4: A write-class request that matches a pending write entry gets 2'b10, and a read-class request that matches a pending read or write entry gets 2'b10.
- R5: A request that is neither full nor aliased gets status 2'b01 (issued) in the same cycle. It is inserted at the clock edge, and the outstanding count rises by one.
- R6: A read completion removes the read entry for its line, and a write completion removes the write entry for its line. Each removal lowers the count by one. In the completion's cycle, the matching latency output is valid and carries the number of cycles since the request was issued.
- R7: The outstanding count always equals read-table occupancy plus write-table occupancy and never exceeds MAX_OUT.
- R8: deadlock_o is high exactly while some pending entry has an age of at least DL_THRESH cycles. It goes low once no such entry remains.
- R9: A completion whose line has no entry in its own table sets err_o at the next edge. err_o stays set until reset, and reset clears it.
- R10: When req_valid_i is low, req_status_o is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | New request present |
| req_addr_i | input | AW | Request byte address |
| req_type_i | input | 4 | Request type code |
| req_status_o | output | 2 | 00 none, 01 issued, 10 aliased, 11 full |
| rd_cpl_valid_i | input | 1 | Read completion present |
| rd_cpl_addr_i | input | AW | Read completion address |
| wr_cpl_valid_i | input | 1 | Write completion present |
| wr_cpl_addr_i | input | AW | Write completion address |
| rd_lat_valid_o | output | 1 | Read completion hit with non-zero latency |
| rd_lat_o | output | TW | Read latency in cycles |
| wr_lat_valid_o | output | 1 | Write completion hit with non-zero latency |
| wr_lat_o | output | TW | Write latency in cycles |
| deadlock_o | output | 1 | Some entry reached the age threshold |
| err_o | output | 1 | Sticky unmatched-completion flag |

## Verification
Request status and completion latency are combinational on the current table state. The bench therefore reads them one time unit after it drives the inputs, before the edge that commits the change. The effects of inserts and removals become visible only after that edge: the count through the full and alias outcomes of later requests, and err_o and deadlock_o one edge after their cause. Those checks are made in the following cycle. Latency expectations come from a bench cycle counter that advances on the same edges as the design's timer. The age at which deadlock_o rises is counted edge by edge from the edge that inserts the entry.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [1:0] {
    ST_NONE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_ALIAS = 2'b10,
    ST_FULL  = 2'b11
  } req_status_e;

  function automatic logic is_write_class(input logic [3:0] t);
    return (t >= 4'd2) && (t <= 4'd9);
  endfunction
endpackage

// File: rtl/mrt_table.sv
module mrt_table #(
  parameter int N      = 4,
  parameter int LW     = 26,
  parameter int TW     = 16,
  parameter int THRESH = 200,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] now_i,
  input  logic [LW-1:0] look_line_i,
  output logic          look_hit_o,
  input  logic          ins_i,
  input  logic [LW-1:0] ins_line_i,
  input  logic          rm_i,
  input  logic [LW-1:0] rm_line_i,
  output logic          rm_hit_o,
  output logic [TW-1:0] rm_ts_o,
  output logic [CW-1:0] cnt_o,
  output logic          stale_o
);
  logic [N-1:0]  vld_q;
  logic [LW-1:0] line_q [N];
  logic [TW-1:0] ts_q   [N];
  logic [N-1:0]  look_vec, rm_vec, old_vec;
  logic          free_found;
  logic [$clog2(N > 1 ? N : 2)-1:0] free_idx;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [TW-1:0] age;
    assign age         = now_i - ts_q[i];
    assign look_vec[i] = vld_q[i] && (line_q[i] == look_line_i);
    assign rm_vec[i]   = vld_q[i] && (line_q[i] == rm_line_i);
    assign old_vec[i]  = vld_q[i] && (age >= TW'(THRESH));
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    rm_ts_o    = '0;
    cnt_o      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = i[$bits(free_idx)-1:0];
      end
    end
    for (int i = 0; i < N; i++) begin
      if (rm_vec[i]) rm_ts_o = rm_ts_o | ts_q[i];
      cnt_o = cnt_o + CW'(vld_q[i]);
    end
  end

  assign look_hit_o = |look_vec;
  assign rm_hit_o   = rm_i && |rm_vec;
  assign stale_o    = |old_vec;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i]  <= 1'b0;
        line_q[i] <= '0;
        ts_q[i]   <= '0;
      end else if (ins_i && free_found && (free_idx == i)) begin
        vld_q[i]  <= 1'b1;
        line_q[i] <= ins_line_i;
        ts_q[i]   <= now_i;
      end else if (rm_i && rm_vec[i]) begin
        vld_q[i]  <= 1'b0;
      end
    end
  end

  // R4: a line is held at most once per table
  a_r4_unique_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(look_vec));
  // R7: insert must find a free slot
  a_r7_slot_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> free_found);
  // R6: a hit removal frees the entry
  a_r6_entry_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rm_hit_o && !ins_i) |=> (cnt_o == $past(cnt_o) - CW'(1)));
endmodule

// File: rtl/mem_req_tracker.sv
module mem_req_tracker #(
  parameter int AW        = 32,
  parameter int LINE_OFS  = 6,
  parameter int MAX_OUT   = 4,
  parameter int TW        = 16,
  parameter int DL_THRESH = 200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [3:0]    req_type_i,
  output logic [1:0]    req_status_o,
  input  logic          rd_cpl_valid_i,
  input  logic [AW-1:0] rd_cpl_addr_i,
  input  logic          wr_cpl_valid_i,
  input  logic [AW-1:0] wr_cpl_addr_i,
  output logic          rd_lat_valid_o,
  output logic [TW-1:0] rd_lat_o,
  output logic          wr_lat_valid_o,
  output logic [TW-1:0] wr_lat_o,
  output logic          deadlock_o,
  output logic          err_o
);
  import mrt_pkg::*;

  localparam int LW = AW - LINE_OFS;
  localparam int CW = $clog2(MAX_OUT + 1);

  logic [TW-1:0] now_q;
  logic [CW-1:0] cnt_q, rd_cnt, wr_cnt;
  logic          err_q;
  logic [LW-1:0] req_line;
  logic          wr_cls, full, rd_look, wr_look, alias_hit, accept;
  logic          rd_rm, wr_rm, rd_stale, wr_stale;
  logic [TW-1:0] rd_ts, wr_ts;
  req_status_e   status;

  assign req_line  = req_addr_i[AW-1:LINE_OFS];
  assign wr_cls    = is_write_class(req_type_i);
  assign full      = cnt_q >= CW'(MAX_OUT);
  assign alias_hit = wr_look || (wr_cls ? 1'b0 : rd_look) || (wr_cls && rd_look);

  always_comb begin
    if (!req_valid_i)   status = ST_NONE;
    else if (full)      status = ST_FULL;
    else if (alias_hit) status = ST_ALIAS;
    else                status = ST_ISSUE;
  end
  assign accept       = (status == ST_ISSUE);
  assign req_status_o = status;

  mrt_table #(.N(MAX_OUT), .LW(LW), .TW(TW), .THRESH(DL_THRESH)) u_rd_tbl (
    .clk_i, .rst_ni, .now_i(now_q),
    .look_line_i(req_line), .look_hit_o(rd_look),
    .ins_i(accept && !wr_cls), .ins_line_i(req_line),
    .rm_i(rd_cpl_valid_i), .rm_line_i(rd_cpl_addr_i[AW-1:LINE_OFS]),
    .rm_hit_o(rd_rm), .rm_ts_o(rd_ts), .cnt_o(rd_cnt), .stale_o(rd_stale)
  );

  mrt_table #(.N(MAX_OUT), .LW(LW), .TW(TW), .THRESH(DL_THRESH)) u_wr_tbl (
    .clk_i, .rst_ni, .now_i(now_q),
    .look_line_i(req_line), .look_hit_o(wr_look),
    .ins_i(accept && wr_cls), .ins_line_i(req_line),
    .rm_i(wr_cpl_valid_i), .rm_line_i(wr_cpl_addr_i[AW-1:LINE_OFS]),
    .rm_hit_o(wr_rm), .rm_ts_o(wr_ts), .cnt_o(wr_cnt), .stale_o(wr_stale)
  );

  assign rd_lat_o       = now_q - rd_ts;
  assign wr_lat_o       = now_q - wr_ts;
  assign rd_lat_valid_o = rd_rm && (rd_lat_o != '0);
  assign wr_lat_valid_o = wr_rm && (wr_lat_o != '0);
  assign deadlock_o     = rd_stale || wr_stale;
  assign err_o          = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      now_q <= now_q + TW'(1);
      cnt_q <= cnt_q + CW'(accept) - CW'(rd_rm) - CW'(wr_rm);
      err_q <= err_q || (rd_cpl_valid_i && !rd_rm) || (wr_cpl_valid_i && !wr_rm);
    end
  end

  a_r7_count_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == rd_cnt + wr_cnt);
  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_OUT));
  a_r5_issue_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !rd_cpl_valid_i && !wr_cpl_valid_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  a_r3_write_over_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && wr_cls && rd_look && !full) |-> (req_status_o == 2'b10));
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r10_idle_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (req_status_o == 2'b00));
endmodule

// File: tb/mem_req_tracker_bench.sv
module mem_req_tracker_bench;
  localparam int AW = 32;
  localparam int TW = 16;
  localparam int THR = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_v = 1'b0, rc_v = 1'b0, wc_v = 1'b0;
  logic [AW-1:0] req_a = '0, rc_a = '0, wc_a = '0;
  logic [3:0] req_t = '0;
  logic [1:0] stat;
  logic rl_v, wl_v, dl, err;
  logic [TW-1:0] rl, wl;
  int checks = 0, fails = 0, cyc = 0;
  int t0 = 0, t1 = 0, t2 = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  mem_req_tracker #(.AW(AW), .MAX_OUT(4), .TW(TW), .DL_THRESH(THR)) u_mem_req_tracker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_addr_i(req_a),
    .req_type_i(req_t), .req_status_o(stat), .rd_cpl_valid_i(rc_v),
    .rd_cpl_addr_i(rc_a), .wr_cpl_valid_i(wc_v), .wr_cpl_addr_i(wc_a),
    .rd_lat_valid_o(rl_v), .rd_lat_o(rl), .wr_lat_valid_o(wl_v), .wr_lat_o(wl),
    .deadlock_o(dl), .err_o(err)
  );

  // {addr, type, expected status}
  localparam logic [37:0] VEC [10] = '{
    {32'h0000_1000, 4'd0, 2'b01},  // R5 load issued
    {32'h0000_1008, 4'd0, 2'b10},  // R4 read vs read
    {32'h0000_1000, 4'd2, 2'b10},  // R3 store vs read
    {32'h0000_2040, 4'd2, 2'b01},  // R5 store issued
    {32'h0000_2050, 4'd1, 2'b10},  // R4 ifetch vs write
    {32'h0000_2040, 4'd9, 2'b10},  // R4 flush vs write
    {32'h0000_3080, 4'd5, 2'b01},  // R2 load-linked issued
    {32'h0000_40C0, 4'd1, 2'b01},  // R2 ifetch issued, count 4
    {32'h0000_5000, 4'd0, 2'b11},  // R1 full
    {32'h0000_1000, 4'd2, 2'b11}   // R1 full before alias
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [31:0] ra, input logic [3:0] rt,
                       input logic cr, input logic [31:0] ca,
                       input logic cw, input logic [31:0] wa);
    @(negedge clk);
    req_v = rv; req_a = ra; req_t = rt;
    rc_v = cr; rc_a = ca; wc_v = cw; wc_a = wa;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_v = 0; rc_v = 0; wc_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R10 reset status", 32'(stat), 0);
    chk("R8 reset deadlock", 32'(dl), 0);
    chk("R9 reset err", 32'(err), 0);
    chk("R6 reset lat valid", 32'({rl_v, wl_v}), 0);

    for (int i = 0; i < 10; i++) begin
      drive(1, VEC[i][37:6], VEC[i][5:2], 0, 0, 0, 0);
      if (i == 0) t0 = cyc;
      if (i == 3) t1 = cyc;
      if (i == 6) t2 = cyc;
      chk($sformatf("R1-vector %0d status (R3 R4 R5)", i), 32'(stat), 32'(VEC[i][1:0]));
    end

    // R6 read completion with a full request in the same cycle
    drive(1, 32'h5000, 4'd0, 1, 32'h1010, 0, 0);
    chk("R1 full during completion", 32'(stat), 3);
    chk("R6 read lat valid", 32'(rl_v), 1);
    chk("R6 read latency", 32'(rl), 32'(cyc - t0));
    drive(1, 32'h1000, 4'd2, 0, 0, 0, 0);
    chk("R6 read entry removed, store issued", 32'(stat), 1);
    drive(1, 32'h5000, 4'd0, 0, 0, 0, 0);
    chk("R7 count back at max", 32'(stat), 3);
    drive(0, 0, 0, 0, 0, 1, 32'h2044);
    chk("R10 idle during completion", 32'(stat), 0);
    chk("R6 write latency", 32'(wl), 32'(cyc - t1));
    chk("R6 write lat valid", 32'(wl_v), 1);
    drive(1, 32'h2040, 4'd0, 0, 0, 0, 0);
    chk("R6 write entry removed, load issued", 32'(stat), 1);
    // R2: load-linked line sits in the write table, so a read completion misses
    drive(0, 0, 0, 1, 32'h3080, 0, 0);
    chk("R2 LL not in read table", 32'(rl_v), 0);
    chk("R9 err not yet", 32'(err), 0);
    drive(0, 0, 0, 0, 0, 1, 32'h3080);
    chk("R9 err set after miss", 32'(err), 1);
    chk("R2 LL in write table", 32'(wl_v), 1);
    chk("R2 LL latency", 32'(wl), 32'(cyc - t2));
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R9 err sticky", 32'(err), 1);

    // R8 age watchdog
    do_reset();
    chk("R9 err cleared by reset", 32'(err), 0);
    drive(1, 32'h1000, 4'd0, 0, 0, 0, 0);
    chk("R5 issue after reset", 32'(stat), 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R8 young entry", 32'(dl), 0);
    for (int k = 2; k < THR; k++) drive(0, 0, 0, 0, 0, 0, 0);
    chk("R8 age THR-1", 32'(dl), 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R8 age THR", 32'(dl), 1);
    drive(0, 0, 0, 1, 32'h1000, 0, 0);
    chk("R6 late completion latency", 32'(rl), THR + 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R8 alarm clears", 32'(dl), 0);
    chk("R9 no err on hit", 32'(err), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule